// File: doc/BRIEF.md
# Single-Line Migratory Coherence Engine

This block keeps one cache line coherent among a few remote cache agents and a single home directory. The line migrates: only one agent holds it at a time, and the holder may change its copy freely. An agent that wants the line asks the home. The home grants the line straight away when nobody holds it. When another agent holds it, the home first recalls the line with an invalidation, waits for the data to come back, and then hands the line and that data to the new requester. A holder may also give the line back on its own, returning its data with the release.

Every agent talks only to the home, over a pair of order-preserving FIFO links, one for each direction. Messages carry a kind, a data byte and a node number. Two races are resolved by fixed rules, so neither side is ever left holding a message it cannot handle. First, a holder may release the line at the same moment the home is recalling it. The home accepts the release as the answer to its recall, and the agent throws away the invalidation that arrives after it has already let go. Second, a request may reach the home while a recall is still in progress. The home refuses it with a negative acknowledgement, and the agent sends the request again without any further stimulus.

Top module: `mig_coherence`

## Requirements
- R1: After synchronous reset, no agent holds the line. The home reports the line free and its stored data equals the INIT_DATA parameter.
- R2: A request for a free line makes the requester valid, holding the home's stored data. The home reports the line owned, with owner equal to the requester's index.
- R3: At no clock edge is more than one agent valid.
- R4: A release by the holder makes it invalid and frees the line at the home. The home's stored data then equals the last value the holder wrote.
- R5: A request while another agent holds the line invalidates the holder first. The requester then becomes valid with the holder's latest data and becomes the recorded owner.
- R6: Take a holder that releases in the same cycle the home sends it an invalidation. The home accepts the release as the recall's answer and grants the released data to the requester. The former holder discards the late invalidation and stays invalid.
- R7: A request that reaches the home during a recall is refused (message kind 6). The refused agent reissues its request on its own and eventually obtains the line. No link ever overflows.
- R8: Certain inputs have no effect: a request from an agent that is already valid, a release from an invalid agent, and a data update on an invalid agent. None of them changes any valid bit, any held data, the owner or the home's stored data.
- R9: Whenever an agent becomes valid, its data equals the data most recently returned to the home. Before any return, that is INIT_DATA. Message kinds: request 1, grant 2, invalidate 3, release 4, invalidate-done 5, refuse 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | NUM_REMOTES | One-cycle pulse per agent: obtain the line |
| evict_req | input | NUM_REMOTES | One-cycle pulse per agent: give the line back |
| upd_en | input | NUM_REMOTES | Per agent: overwrite the held copy this cycle |
| upd_data | input | NUM_REMOTES*8 | New copy value per agent, agent i in bits [8i+7:8i] |
| line_valid | output | NUM_REMOTES | Per agent: line held |
| line_data | output | NUM_REMOTES*8 | Per agent held copy, agent i in bits [8i+7:8i] |
| home_owned | output | 1 | Home considers the line held by some agent |
| home_owner | output | 2 | Index of the recorded holder |
| home_data | output | 8 | Data stored at the home |

## Verification
The bench builds the block with three agents and two-entry links. Three agents are the fewest that allow a crossing release and a refused request to occur in the same run. With those settings, a simultaneous request from two agents against a third holder forces one request to be refused and reissued. Two-entry links are the tightest setting that still holds a stale invalidation followed by a grant, so an undersized link shows up as an overflow.

// File: rtl/mig_pkg.sv
package mig_pkg;
  localparam int DATA_W = 8;
  localparam int NODE_W = 2;

  typedef enum logic [2:0] {
    MSG_NONE  = 3'd0,
    MSG_REQ   = 3'd1,
    MSG_GRANT = 3'd2,
    MSG_INV   = 3'd3,
    MSG_REL   = 3'd4,
    MSG_IDONE = 3'd5,
    MSG_NACK  = 3'd6
  } msg_kind_e;

  typedef struct packed {
    msg_kind_e           kind;
    logic [DATA_W-1:0]   data;
    logic [NODE_W-1:0]   node;
  } msg_t;

  typedef enum logic [1:0] {R_INV, R_WAIT, R_VALID} rstate_e;
  typedef enum logic [1:0] {H_FREE, H_OWNED, H_RECALL} hstate_e;
endpackage

// File: rtl/mig_link.sv
module mig_link
  import mig_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  msg_t din,
  input  logic pop,
  output msg_t dout,
  output logic has_data,
  output logic full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  msg_t           slots [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  count;
  logic           do_push, do_pop;

  assign has_data = (count != '0);
  assign full     = (count == CW'(DEPTH));
  assign do_push  = push && !full;
  assign do_pop   = pop && has_data;
  assign dout     = slots[rp];

  always_ff @(posedge clk) begin
    if (do_push) slots[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mig_remote.sv
module mig_remote
  import mig_pkg::*;
#(
  parameter logic [NODE_W-1:0] ID = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acq,
  input  logic              evict,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] upd_data,
  input  logic              rx_valid,
  input  msg_t              rx_msg,
  output logic              rx_pop,
  output logic              tx_push,
  output msg_t              tx_msg,
  output logic              line_valid,
  output logic [DATA_W-1:0] line_data
);
  rstate_e state;
  logic    pend;
  logic    mine, got_inv, got_grant, got_nack;

  assign rx_pop    = rx_valid;
  assign mine      = rx_valid && (rx_msg.node == ID);
  assign got_inv   = mine && (rx_msg.kind == MSG_INV);
  assign got_grant = mine && (rx_msg.kind == MSG_GRANT);
  assign got_nack  = mine && (rx_msg.kind == MSG_NACK);
  assign line_valid = (state == R_VALID);

  always_comb begin
    tx_push = 1'b0;
    tx_msg  = '{kind: MSG_NONE, data: '0, node: ID};
    case (state)
      R_INV: if (acq || pend) begin
        tx_push     = 1'b1;
        tx_msg.kind = MSG_REQ;
      end
      R_VALID: if (got_inv) begin
        tx_push     = 1'b1;
        tx_msg.kind = MSG_IDONE;
        tx_msg.data = line_data;
      end else if (evict) begin
        tx_push     = 1'b1;
        tx_msg.kind = MSG_REL;
        tx_msg.data = line_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= R_INV;
      pend      <= 1'b0;
      line_data <= '0;
    end else begin
      if (state == R_WAIT && got_grant) pend <= 1'b0;
      else if (acq && state != R_VALID) pend <= 1'b1;
      case (state)
        R_INV: if (acq || pend) state <= R_WAIT;
        R_WAIT: begin
          if (got_grant) begin
            state     <= R_VALID;
            line_data <= rx_msg.data;
          end else if (got_nack) begin
            state <= R_INV;
          end
        end
        R_VALID: begin
          if (got_inv || evict) state <= R_INV;
          else if (upd_en) line_data <= upd_data;
        end
        default: state <= R_INV;
      endcase
    end
  end
endmodule

// File: rtl/mig_home.sv
module mig_home
  import mig_pkg::*;
#(
  parameter int                NR        = 3,
  parameter logic [DATA_W-1:0] INIT_DATA = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NR-1:0]     rx_valid,
  input  msg_t              rx_msg [NR],
  output logic [NR-1:0]     rx_pop,
  output logic [NR-1:0]     tx_push,
  output msg_t              tx_msg,
  output logic              owned,
  output logic [NODE_W-1:0] owner,
  output logic [DATA_W-1:0] mem_data
);
  hstate_e           state;
  logic [NODE_W-1:0] pend, rr, sel, src;
  logic              any;
  msg_t              head;

  assign owned = (state != H_FREE);

  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int k = NR - 1; k >= 0; k--) begin
      if (rx_valid[(int'(rr) + k) % NR]) begin
        any = 1'b1;
        sel = NODE_W'((int'(rr) + k) % NR);
      end
    end
  end

  assign head = rx_msg[sel];
  assign src  = head.node;

  always_comb begin
    rx_pop  = '0;
    tx_push = '0;
    tx_msg  = '{kind: MSG_NONE, data: '0, node: '0};
    if (any) begin
      rx_pop[sel] = 1'b1;
      case (state)
        H_FREE: if (head.kind == MSG_REQ) begin
          tx_push[src] = 1'b1;
          tx_msg       = '{kind: MSG_GRANT, data: mem_data, node: src};
        end
        H_OWNED: if (head.kind == MSG_REQ && src != owner) begin
          tx_push[owner] = 1'b1;
          tx_msg         = '{kind: MSG_INV, data: '0, node: owner};
        end
        H_RECALL: begin
          if ((head.kind == MSG_REL || head.kind == MSG_IDONE) && src == owner) begin
            tx_push[pend] = 1'b1;
            tx_msg        = '{kind: MSG_GRANT, data: head.data, node: pend};
          end else if (head.kind == MSG_REQ) begin
            tx_push[src] = 1'b1;
            tx_msg       = '{kind: MSG_NACK, data: '0, node: src};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= H_FREE;
      owner    <= '0;
      pend     <= '0;
      rr       <= '0;
      mem_data <= INIT_DATA;
    end else if (any) begin
      rr <= (sel == NODE_W'(NR - 1)) ? '0 : sel + 1'b1;
      case (state)
        H_FREE: if (head.kind == MSG_REQ) begin
          owner <= src;
          state <= H_OWNED;
        end
        H_OWNED: begin
          if (head.kind == MSG_REQ && src != owner) begin
            pend  <= src;
            state <= H_RECALL;
          end else if (head.kind == MSG_REL && src == owner) begin
            mem_data <= head.data;
            state    <= H_FREE;
          end
        end
        H_RECALL: if ((head.kind == MSG_REL || head.kind == MSG_IDONE) && src == owner) begin
          mem_data <= head.data;
          owner    <= pend;
          state    <= H_OWNED;
        end
        default: state <= H_FREE;
      endcase
    end
  end
endmodule

// File: rtl/mig_coherence.sv
module mig_coherence
  import mig_pkg::*;
#(
  parameter int                NUM_REMOTES = 3,
  parameter int                LINK_DEPTH  = 2,
  parameter logic [DATA_W-1:0] INIT_DATA   = 8'hA5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_REMOTES-1:0]        acq_req,
  input  logic [NUM_REMOTES-1:0]        evict_req,
  input  logic [NUM_REMOTES-1:0]        upd_en,
  input  logic [NUM_REMOTES*DATA_W-1:0] upd_data,
  output logic [NUM_REMOTES-1:0]        line_valid,
  output logic [NUM_REMOTES*DATA_W-1:0] line_data,
  output logic                          home_owned,
  output logic [NODE_W-1:0]             home_owner,
  output logic [DATA_W-1:0]             home_data
);
  localparam int NR = NUM_REMOTES;

  logic [NR-1:0] up_push, up_full, up_has, up_pop;
  logic [NR-1:0] dn_push, dn_full, dn_has, dn_pop;
  msg_t          up_din [NR];
  msg_t          up_dout [NR];
  msg_t          dn_dout [NR];
  msg_t          dn_din;

  // Observation points for the bound checker
  logic              obs_grant, obs_ret;
  logic [DATA_W-1:0] obs_grant_data, obs_ret_data;

  for (genvar i = 0; i < NR; i++) begin : g_node
    mig_link #(.DEPTH(LINK_DEPTH)) u_up (
      .clk(clk), .rst(rst), .push(up_push[i]), .din(up_din[i]),
      .pop(up_pop[i]), .dout(up_dout[i]), .has_data(up_has[i]), .full(up_full[i])
    );
    mig_link #(.DEPTH(LINK_DEPTH)) u_dn (
      .clk(clk), .rst(rst), .push(dn_push[i]), .din(dn_din),
      .pop(dn_pop[i]), .dout(dn_dout[i]), .has_data(dn_has[i]), .full(dn_full[i])
    );
    mig_remote #(.ID(NODE_W'(i))) u_rem (
      .clk(clk), .rst(rst),
      .acq(acq_req[i]), .evict(evict_req[i]),
      .upd_en(upd_en[i]), .upd_data(upd_data[i*DATA_W +: DATA_W]),
      .rx_valid(dn_has[i]), .rx_msg(dn_dout[i]), .rx_pop(dn_pop[i]),
      .tx_push(up_push[i]), .tx_msg(up_din[i]),
      .line_valid(line_valid[i]), .line_data(line_data[i*DATA_W +: DATA_W])
    );
  end

  mig_home #(.NR(NR), .INIT_DATA(INIT_DATA)) u_home (
    .clk(clk), .rst(rst),
    .rx_valid(up_has), .rx_msg(up_dout), .rx_pop(up_pop),
    .tx_push(dn_push), .tx_msg(dn_din),
    .owned(home_owned), .owner(home_owner), .mem_data(home_data)
  );

  assign obs_grant      = (dn_push != '0) && (dn_din.kind == MSG_GRANT);
  assign obs_grant_data = dn_din.data;

  always_comb begin
    obs_ret      = 1'b0;
    obs_ret_data = '0;
    for (int i = 0; i < NR; i++) begin
      if (up_pop[i] && up_has[i] &&
          (up_dout[i].kind == MSG_REL || up_dout[i].kind == MSG_IDONE)) begin
        obs_ret      = 1'b1;
        obs_ret_data = up_dout[i].data;
      end
    end
  end
endmodule

// File: rtl/mig_checker.sv
module mig_checker
  import mig_pkg::*;
#(
  parameter int                NR        = 3,
  parameter logic [DATA_W-1:0] INIT_DATA = 8'hA5
) (
  input logic              clk,
  input logic              rst,
  input logic [NR-1:0]     line_valid,
  input logic              home_owned,
  input logic [NODE_W-1:0] home_owner,
  input logic [NR-1:0]     up_push,
  input logic [NR-1:0]     up_full,
  input logic [NR-1:0]     dn_push,
  input logic [NR-1:0]     dn_full,
  input logic              obs_grant,
  input logic [DATA_W-1:0] obs_grant_data,
  input logic              obs_ret,
  input logic [DATA_W-1:0] obs_ret_data
);
  logic [DATA_W-1:0] last_ret;

  always_ff @(posedge clk) begin
    if (rst) last_ret <= INIT_DATA;
    else if (obs_ret) last_ret <= obs_ret_data;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (line_valid == '0 && !home_owned));

  // R3
  one_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(line_valid) <= 1);

  // R4
  free_clean_chk: assert property (@(posedge clk) disable iff (rst)
    !home_owned |-> (line_valid == '0));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ((up_push & up_full) == '0) && ((dn_push & dn_full) == '0));

  // R9
  grant_data_chk: assert property (@(posedge clk) disable iff (rst)
    (obs_grant && !obs_ret) |-> (obs_grant_data == last_ret));

  for (genvar i = 0; i < NR; i++) begin : g_own
    // R2
    owner_match_chk: assert property (@(posedge clk) disable iff (rst)
      line_valid[i] |-> (home_owned && home_owner == NODE_W'(i)));
  end
endmodule

bind mig_coherence mig_checker #(.NR(NUM_REMOTES), .INIT_DATA(INIT_DATA)) u_chk (
  .clk(clk), .rst(rst), .line_valid(line_valid),
  .home_owned(home_owned), .home_owner(home_owner),
  .up_push(up_push), .up_full(up_full), .dn_push(dn_push), .dn_full(dn_full),
  .obs_grant(obs_grant), .obs_grant_data(obs_grant_data),
  .obs_ret(obs_ret), .obs_ret_data(obs_ret_data)
);

// File: tb/sim_mig_coherence.sv
module sim_mig_coherence;
  localparam int NR = 3;
  localparam int DW = 8;
  localparam logic [7:0] INIT = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NR-1:0]    acq_req = '0, evict_req = '0, upd_en = '0;
  logic [NR*DW-1:0] upd_data = '0;
  logic [NR-1:0]    line_valid;
  logic [NR*DW-1:0] line_data;
  logic             home_owned;
  logic [1:0]       home_owner;
  logic [7:0]       home_data;

  int checks = 0, errors = 0;
  int r3_bad = 0, r9_bad = 0;
  int rises [NR];
  logic [NR-1:0] prev_valid = '0;
  logic [7:0]    last_ret = INIT;
  bit            done = 0;

  always #2.5 clk = ~clk;

  mig_coherence #(.NUM_REMOTES(NR), .LINK_DEPTH(2), .INIT_DATA(INIT)) u0 (
    .clk(clk), .rst(rst), .acq_req(acq_req), .evict_req(evict_req),
    .upd_en(upd_en), .upd_data(upd_data), .line_valid(line_valid),
    .line_data(line_data), .home_owned(home_owned), .home_owner(home_owner),
    .home_data(home_data)
  );

  function automatic logic [7:0] dat(int i);
    return line_data[i*DW +: DW];
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitors: sampled on the falling edge
  initial for (int i = 0; i < NR; i++) rises[i] = 0;
  always @(negedge clk) if (!rst) begin
    if ($countones(line_valid) > 1) r3_bad++;
    for (int i = 0; i < NR; i++)
      if (prev_valid[i] && !line_valid[i]) last_ret = dat(i);
    for (int i = 0; i < NR; i++)
      if (!prev_valid[i] && line_valid[i]) begin
        rises[i]++;
        if (dat(i) != last_ret) r9_bad++;
      end
    prev_valid = line_valid;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic [NR-1:0] sig, input int i);
    @(negedge clk);
    sig[i] = 1'b1;
    @(negedge clk);
    sig[i] = 1'b0;
  endtask

  task automatic write_copy(int i, logic [7:0] d);
    @(negedge clk);
    upd_en[i] = 1'b1;
    upd_data[i*DW +: DW] = d;
    @(negedge clk);
    upd_en[i] = 1'b0;
  endtask

  task automatic t_reset();
    check(line_valid == '0, "R1 valid", line_valid, 0);
    check(!home_owned, "R1 owned", home_owned, 0);
    check(home_data == INIT, "R1 data", home_data, INIT);
  endtask

  task automatic t_acquire();
    pulse(acq_req, 0);
    idle(10);
    check(line_valid == 3'b001, "R2 valid", line_valid, 3'b001);
    check(dat(0) == INIT, "R2 data", dat(0), INIT);
    check(home_owned && home_owner == 2'd0, "R2 owner", home_owner, 0);
  endtask

  task automatic t_migrate();
    write_copy(0, 8'h3C);
    pulse(acq_req, 1);
    idle(12);
    check(line_valid == 3'b010, "R5 valid", line_valid, 3'b010);
    check(dat(1) == 8'h3C, "R5 data", dat(1), 8'h3C);
    check(home_owner == 2'd1, "R5 owner", home_owner, 1);
  endtask

  task automatic t_release();
    write_copy(1, 8'h77);
    pulse(evict_req, 1);
    idle(10);
    check(line_valid == '0, "R4 valid", line_valid, 0);
    check(!home_owned, "R4 owned", home_owned, 0);
    check(home_data == 8'h77, "R4 data", home_data, 8'h77);
  endtask

  task automatic t_ignored();
    pulse(evict_req, 2);
    write_copy(2, 8'hEE);
    idle(10);
    check(line_valid == '0 && !home_owned, "R8 stray release", {home_owned, line_valid}, 0);
    check(home_data == 8'h77, "R8 home data", home_data, 8'h77);
    pulse(acq_req, 2);
    idle(10);
    check(dat(2) == 8'h77, "R8 update while invalid dropped", dat(2), 8'h77);
    pulse(acq_req, 2);
    pulse(evict_req, 0);
    idle(10);
    check(line_valid == 3'b100 && home_owner == 2'd2, "R8 repeat request", line_valid, 3'b100);
    check(dat(2) == 8'h77 && home_data == 8'h77, "R8 data kept", dat(2), 8'h77);
  endtask

  task automatic t_cross();
    write_copy(2, 8'h11);
    @(negedge clk);
    acq_req[0] = 1'b1;
    @(negedge clk);
    acq_req[0] = 1'b0;
    evict_req[2] = 1'b1;
    @(negedge clk);
    evict_req[2] = 1'b0;
    idle(12);
    check(line_valid == 3'b001, "R6 valid", line_valid, 3'b001);
    check(dat(0) == 8'h11, "R6 data", dat(0), 8'h11);
    check(home_owner == 2'd0 && home_data == 8'h11, "R6 home", home_data, 8'h11);
  endtask

  task automatic t_refuse();
    int r1, r2;
    write_copy(0, 8'h42);
    r1 = rises[1];
    r2 = rises[2];
    @(negedge clk);
    acq_req[1] = 1'b1;
    acq_req[2] = 1'b1;
    @(negedge clk);
    acq_req = '0;
    idle(40);
    check(rises[1] == r1 + 1 && rises[2] == r2 + 1, "R7 both served",
          (rises[1] - r1) * 16 + (rises[2] - r2), 8'h11);
    check(line_valid == 3'b010 || line_valid == 3'b100, "R7 one holder", line_valid, 3'b100);
    check((line_valid[1] ? dat(1) : dat(2)) == 8'h42, "R7 data",
          line_valid[1] ? dat(1) : dat(2), 8'h42);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_acquire();
    t_migrate();
    t_release();
    t_ignored();
    t_cross();
    t_refuse();
    check(r3_bad == 0, "R3 single holder", r3_bad, 0);
    check(r9_bad == 0, "R9 grant data", r9_bad, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule